// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Engine

This block is a four-channel direct memory access engine. Software sets it up through byte-wide writes to a small port space. Through those writes it picks each channel's transfer direction, loads a 16-bit start address and a 16-bit transfer count, sets an 8-bit page byte for the upper address bits, and masks or unmasks each channel on its own. Address and count bytes go through one shared low/high byte pointer. A dedicated strobe port returns that pointer to the low byte.

When a device raises its request line on an unmasked channel, the engine grants exactly one transfer. It gives a one-cycle acknowledge together with the 24-bit memory address (page byte above the 16-bit address) and the memory strobe for the chosen direction. It then steps the address up and the count down. The address never carries into the page byte, so a buffer wraps inside its 64 KB page. When the count passes below zero the engine signals terminal count, masks the channel and raises a status bit for it.

Top module: `dma4_core`

## Requirements
- R1: After reset every channel is masked, the byte pointer selects the low byte, `dack`, `mem_rd`, `mem_wr` and `tc_pulse` are low and `tc_status` is zero.
- R2: Channel n's address register sits at port 2n and its count register at port 2n+1. One byte pointer is shared by all of these ports. A write loads the low byte while the pointer is clear and the high byte while it is set, and every such write flips the pointer.
- R3: Any write to port 0Ch clears the byte pointer, whatever data is written.
- R4: A write to port 0Bh sets the operation of the channel in data bits 1:0 from data bits 3:2. Code 0 (verify) drives no memory strobe. Code 1 (device to memory) drives `mem_wr`. Code 2 (memory to device) drives `mem_rd`. Code 3 drives no strobe. The other data bits are ignored.
- R5: The page bytes of channels 0, 1, 2 and 3 are written at ports 87h, 83h, 81h and 82h. They appear on `mem_addr[23:16]` during that channel's transfers.
- R6: A request sampled while the engine is idle on an unmasked channel gives `dack` high for exactly one cycle on the next cycle, with `mem_addr` set to the channel's page and current address. No new grant is made during that cycle.
- R7: A count value of N gives N+1 transfers. `tc_pulse` is high with `dack` only on the last of them.
- R8: After each transfer the 16-bit address goes up by one and wraps from FFFFh to 0000h. The page byte does not change.
- R9: On the terminal-count transfer the channel becomes masked and its `tc_status` bit goes to 1.
- R10: A write to port 0Ah sets the mask bit of the channel in data bits 1:0 to data bit 2, where 0 enables the channel. Requests on a masked channel produce no transfer. Enabling a channel clears its `tc_status` bit.
- R11: When several unmasked channels request in the same cycle, the lowest-numbered one is served.
- R12: `mem_rd` and `mem_wr` are never high together, and neither is high without `dack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register port number |
| wr_data | input | 8 | Register write data |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel one-cycle acknowledge |
| mem_addr | output | 24 | Page byte and 16-bit address of the transfer |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| tc_pulse | output | 1 | Terminal count, high with the last acknowledge |
| tc_status | output | 4 | Per-channel sticky terminal-count flags |

## Verification
The assertions assume that software never writes a channel's registers in the same cycle in which that channel is transferring, and that a mask write never lands on the same cycle as a terminal-count step. When those coincide the update order is a design choice, not a checked property. The stimulus keeps them apart: requests are one-cycle pulses sent only after all register writes are done, and each pulse is followed by idle cycles before the next write or request. The bench also gives each operation code its own channel and starts addresses just below a page boundary, so that wrap and priority are exercised with no overlapping traffic.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  localparam logic [7:0] PORT_MASK = 8'h0A;
  localparam logic [7:0] PORT_MODE = 8'h0B;
  localparam logic [7:0] PORT_PCLR = 8'h0C;

  typedef enum logic [1:0] {
    OP_CHECK   = 2'd0,
    OP_TO_MEM  = 2'd1,
    OP_TO_DEV  = 2'd2,
    OP_INVALID = 2'd3
  } xfer_op_e;

  // Page byte port for each channel; extra channels beyond four are placed above 88h
  function automatic logic [7:0] page_port(input int ch);
    case (ch)
      0:       return 8'h87;
      1:       return 8'h83;
      2:       return 8'h81;
      3:       return 8'h82;
      default: return 8'h88 + 8'(ch);
    endcase
  endfunction

endpackage

// File: rtl/dma4_decode.sv
module dma4_decode
  import dma4_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [7:0]     wr_addr,
  input  logic [7:0]     wr_data,
  output logic [NCH-1:0] ld_addr_lo,
  output logic [NCH-1:0] ld_addr_hi,
  output logic [NCH-1:0] ld_cnt_lo,
  output logic [NCH-1:0] ld_cnt_hi,
  output logic [NCH-1:0] ld_page,
  output logic [NCH-1:0] ld_mode,
  output logic [NCH-1:0] ld_mask
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [7:0] REG_TOP = 8'(2 * NCH);

  logic hi_sel_q;
  logic hit_regs;
  logic hit_clear;

  assign hit_regs  = wr_en && (wr_addr < REG_TOP);
  assign hit_clear = wr_en && (wr_addr == PORT_PCLR);

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_dec
      logic hit_a;
      logic hit_c;
      assign hit_a = wr_en && (wr_addr == 8'(2 * gi));
      assign hit_c = wr_en && (wr_addr == 8'(2 * gi + 1));
      assign ld_addr_lo[gi] = hit_a && !hi_sel_q;
      assign ld_addr_hi[gi] = hit_a &&  hi_sel_q;
      assign ld_cnt_lo[gi]  = hit_c && !hi_sel_q;
      assign ld_cnt_hi[gi]  = hit_c &&  hi_sel_q;
      assign ld_page[gi]    = wr_en && (wr_addr == page_port(gi));
      assign ld_mode[gi]    = wr_en && (wr_addr == PORT_MODE) && (wr_data[CHW-1:0] == CHW'(gi));
      assign ld_mask[gi]    = wr_en && (wr_addr == PORT_MASK) && (wr_data[CHW-1:0] == CHW'(gi));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            hi_sel_q <= 1'b0;
    else if (hit_clear) hi_sel_q <= 1'b0;
    else if (hit_regs)  hi_sel_q <= ~hi_sel_q;
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    hit_clear |=> !hi_sel_q);

  // R2
  ptr_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_regs && !hit_clear) |=> (hi_sel_q != $past(hi_sel_q)));

  // R2
  ld_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi}));

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   data,
  input  logic            ld_addr_lo,
  input  logic            ld_addr_hi,
  input  logic            ld_cnt_lo,
  input  logic            ld_cnt_hi,
  input  logic            ld_page,
  input  logic            ld_mode,
  input  logic            ld_mask,
  input  logic            step,
  output logic [2*DW-1:0] cur_addr,
  output logic [DW-1:0]   page_q,
  output xfer_op_e        op_q,
  output logic            masked,
  output logic            last,
  output logic            tc_flag
);

  localparam int AW = 2 * DW;

  logic [AW-1:0] cnt_q;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cnt_q    <= '0;
      page_q   <= '0;
      op_q     <= OP_CHECK;
      masked   <= 1'b1;
      tc_flag  <= 1'b0;
    end else begin
      if (ld_addr_lo)      cur_addr[DW-1:0]  <= data;
      else if (ld_addr_hi) cur_addr[AW-1:DW] <= data;
      else if (step)       cur_addr <= cur_addr + AW'(1);

      if (ld_cnt_lo)       cnt_q[DW-1:0]  <= data;
      else if (ld_cnt_hi)  cnt_q[AW-1:DW] <= data;
      else if (step)       cnt_q <= cnt_q - AW'(1);

      if (ld_page) page_q <= data;
      if (ld_mode) op_q   <= xfer_op_e'(data[3:2]);

      if (ld_mask) begin
        masked <= data[2];
        if (!data[2]) tc_flag <= 1'b0;
      end else if (step && last) begin
        masked  <= 1'b1;
        tc_flag <= 1'b1;
      end
    end
  end

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_addr_lo && !ld_addr_hi) |=> (cur_addr == AW'($past(cur_addr) + AW'(1))));

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ld_page) |=> $stable(page_q));

  // R9
  tc_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (step && last && !ld_mask) |=> (masked && tc_flag));

  // R10
  unmask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_mask && !data[2]) |=> (!masked && !tc_flag));

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  assign any = |req;

  // R11
  prio_low_chk: assert final (!any || ((req & (gnt - 1'b1)) == '0));

endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic [NCH-1:0]      dreq,
  output logic [NCH-1:0]      dack,
  output logic [3*DW-1:0]     mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                tc_pulse,
  output logic [NCH-1:0]      tc_status
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int AW  = 2 * DW;

  logic [NCH-1:0] ld_addr_lo, ld_addr_hi, ld_cnt_lo, ld_cnt_hi;
  logic [NCH-1:0] ld_page, ld_mode, ld_mask;
  logic [NCH-1:0] mask_v, last_v, step_v, req_v, gnt_v;
  logic [AW-1:0]  addr_a [NCH];
  logic [DW-1:0]  page_a [NCH];
  xfer_op_e       op_a   [NCH];
  logic [CHW-1:0] gnt_idx;
  logic           gnt_any;
  logic           hold_q;
  logic           go;

  dma4_decode #(.NCH(NCH)) u_decode (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ld_addr_lo (ld_addr_lo),
    .ld_addr_hi (ld_addr_hi),
    .ld_cnt_lo  (ld_cnt_lo),
    .ld_cnt_hi  (ld_cnt_hi),
    .ld_page    (ld_page),
    .ld_mode    (ld_mode),
    .ld_mask    (ld_mask)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_ch
      dma4_chan #(.DW(DW)) u_chan (
        .clk        (clk),
        .rst        (rst),
        .data       (wr_data),
        .ld_addr_lo (ld_addr_lo[gc]),
        .ld_addr_hi (ld_addr_hi[gc]),
        .ld_cnt_lo  (ld_cnt_lo[gc]),
        .ld_cnt_hi  (ld_cnt_hi[gc]),
        .ld_page    (ld_page[gc]),
        .ld_mode    (ld_mode[gc]),
        .ld_mask    (ld_mask[gc]),
        .step       (step_v[gc]),
        .cur_addr   (addr_a[gc]),
        .page_q     (page_a[gc]),
        .op_q       (op_a[gc]),
        .masked     (mask_v[gc]),
        .last       (last_v[gc]),
        .tc_flag    (tc_status[gc])
      );
    end
  endgenerate

  assign req_v = dreq & ~mask_v;

  dma4_prio #(.N(NCH), .IW(CHW)) u_prio (
    .req (req_v),
    .gnt (gnt_v),
    .idx (gnt_idx),
    .any (gnt_any)
  );

  assign go     = !hold_q && gnt_any;
  assign step_v = go ? gnt_v : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      dack     <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      hold_q <= go;
      dack   <= step_v;
      if (go) begin
        mem_addr <= {page_a[gnt_idx], addr_a[gnt_idx]};
        mem_rd   <= (op_a[gnt_idx] == OP_TO_DEV);
        mem_wr   <= (op_a[gnt_idx] == OP_TO_MEM);
        tc_pulse <= last_v[gnt_idx];
      end else begin
        mem_rd   <= 1'b0;
        mem_wr   <= 1'b0;
        tc_pulse <= 1'b0;
      end
    end
  end

  // R11
  dack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dack));

  // R6
  dack_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|dack) |=> (dack == '0));

  // R6
  dack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|dack) |-> $past(|(dreq & ~mask_v)));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R12
  strobe_dack_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (|dack));

  // R7
  tc_dack_chk: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> (|dack));

endmodule

// File: tb/dma4_core_bench.sv
module dma4_core_bench;

  typedef struct packed {
    logic [3:0]  dk;
    logic [23:0] ad;
    logic        rd;
    logic        wr;
    logic        tc;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [23:0] mem_addr;
  logic        mem_rd, mem_wr, tc_pulse;
  logic [3:0]  tc_status;

  int n_cmp = 0;
  int n_bad = 0;
  int n_dack = 0;
  item_t sb[$];

  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [7:0]  m_page [4];
  logic [1:0]  m_op   [4];
  logic [3:0]  m_mask = 4'hF;
  logic [3:0]  m_flag = 4'h0;

  always #5 clk = ~clk;

  dma4_core u_dma4_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dreq(dreq), .dack(dack), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .tc_pulse(tc_pulse), .tc_status(tc_status)
  );

  function automatic logic [7:0] pport(input int ch);
    case (ch)
      0: return 8'h87;
      1: return 8'h83;
      2: return 8'h81;
      default: return 8'h82;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = p; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [1:0] op, input logic [15:0] a,
                      input logic [7:0] pg, input logic [15:0] c);
    wr(8'h0B, 8'h40 | {4'h0, op, 2'b00} | 8'(ch));
    wr(8'h0C, 8'hA5);
    wr(8'(2 * ch), a[7:0]);
    wr(8'(2 * ch), a[15:8]);
    wr(pport(ch), pg);
    wr(8'(2 * ch + 1), c[7:0]);
    wr(8'(2 * ch + 1), c[15:8]);
    wr(8'h0A, 8'(ch));
    m_addr[ch] = a; m_cnt[ch] = c; m_page[ch] = pg; m_op[ch] = op;
    m_mask[ch] = 1'b0; m_flag[ch] = 1'b0;
  endtask

  // Driver: pulses requests for one cycle and queues the expected transfer
  task automatic req(input logic [3:0] v);
    item_t it;
    int w;
    @(negedge clk);
    dreq = v;
    w = -1;
    for (int i = 3; i >= 0; i--) if (v[i] && !m_mask[i]) w = i;
    if (w >= 0) begin
      it.dk = 4'(1 << w);
      it.ad = {m_page[w], m_addr[w]};
      it.rd = (m_op[w] == 2'd2);
      it.wr = (m_op[w] == 2'd1);
      it.tc = (m_cnt[w] == 16'h0);
      sb.push_back(it);
      if (it.tc) begin m_mask[w] = 1'b1; m_flag[w] = 1'b1; end
      m_addr[w] = m_addr[w] + 16'h1;
      m_cnt[w]  = m_cnt[w] - 16'h1;
    end
    @(negedge clk);
    dreq = '0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares each acknowledge against the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (|dack) begin
        n_dack++;
        if (sb.size() == 0) begin
          chk(1'b0, "R6/R10", "unexpected dack", 32'(dack), 32'h0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(dack == e.dk, "R11", "dack channel", 32'(dack), 32'(e.dk));
          chk(mem_addr == e.ad, "R8", "mem_addr", 32'(mem_addr), 32'(e.ad));
          chk(mem_rd == e.rd && mem_wr == e.wr, "R4", "strobes rd/wr",
              32'({mem_rd, mem_wr}), 32'({e.rd, e.wr}));
          chk(tc_pulse == e.tc, "R7", "tc_pulse", 32'(tc_pulse), 32'(e.tc));
        end
      end else if (tc_pulse || mem_rd || mem_wr) begin
        chk(1'b0, "R12", "strobe without dack", 32'({tc_pulse, mem_rd, mem_wr}), 32'h0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int nd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dack == 4'h0, "R1", "dack", 32'(dack), 32'h0);
    chk(!mem_rd && !mem_wr && !tc_pulse, "R1", "strobes", 32'({mem_rd, mem_wr, tc_pulse}), 32'h0);
    chk(tc_status == 4'h0, "R1", "tc_status", 32'(tc_status), 32'h0);
    nd = n_dack;
    req(4'hF);
    chk(n_dack == nd, "R1", "masked after reset", 32'(n_dack - nd), 32'h0);

    // R7 R9 three transfers from count 2, memory to device
    prog(0, 2'd2, 16'h1230, 8'h05, 16'd2);
    repeat (3) req(4'b0001);
    chk(tc_status == 4'b0001, "R9", "tc_status ch0", 32'(tc_status), 32'h1);
    nd = n_dack;
    req(4'b0001);
    chk(n_dack == nd, "R9", "masked after tc", 32'(n_dack - nd), 32'h0);

    // R8 R5 wrap inside page, device to memory
    prog(1, 2'd1, 16'hFFFE, 8'h7A, 16'd3);
    repeat (4) req(4'b0010);
    chk(tc_status == 4'b0011, "R9", "tc_status ch1", 32'(tc_status), 32'h3);

    // R4 verify and illegal code drive no strobes
    prog(2, 2'd0, 16'h0040, 8'h11, 16'd5);
    repeat (2) req(4'b0100);
    prog(3, 2'd3, 16'h0100, 8'h22, 16'd5);
    req(4'b1000);

    // R11 fixed priority
    prog(1, 2'd2, 16'h0500, 8'h33, 16'd4);
    req(4'b1110);
    req(4'b1100);

    // R10 mask a channel, then unmask ch0 to clear its flag
    wr(8'h0A, 8'h06);
    m_mask[2] = 1'b1;
    nd = n_dack;
    req(4'b0100);
    chk(n_dack == nd, "R10", "masked request ignored", 32'(n_dack - nd), 32'h0);
    chk(tc_status == 4'b0001, "R10", "tc_status before unmask", 32'(tc_status), 32'h1);
    wr(8'h0A, 8'h00);
    m_mask[0] = 1'b0; m_flag[0] = 1'b0;
    @(negedge clk);
    chk(tc_status == 4'b0000, "R10", "tc_status after unmask", 32'(tc_status), 32'h0);
    req(4'b0001);

    // R2 R3 byte pointer: stray low write, clear with junk data, then pairs
    wr(8'h06, 8'hEE);
    wr(8'h0C, 8'hFF);
    wr(8'h06, 8'h34);
    wr(8'h06, 8'h12);
    wr(8'h07, 8'h00);
    wr(8'h07, 8'h00);
    m_addr[3] = 16'h1234; m_cnt[3] = 16'h0000;
    nd = n_dack;
    req(4'b1000);
    chk(n_dack == nd + 1, "R2", "transfer after reload", 32'(n_dack - nd), 32'h1);
    chk(tc_status[3] == 1'b1, "R3", "tc_status ch3", 32'(tc_status), 32'h8);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R6", "pending expected transfers", 32'(sb.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule